// File: doc/BRIEF.md
# DRAM buffer access arbiter

This block decides which client may use a shared DRAM buffer and times each access. Nine requesters compete for it: five front-end data sources, a microcontroller, a SCSI interface, an ECC engine, and a refresh timer inside the block. Every client holds a request level. The arbiter answers with a one-hot grant that starts on the clock edge after it sees the request. The grant stays up for the whole access, and a done pulse marks the last cycle of that access.

An access lasts a fixed number of clocks. The count depends on the memory width, which is sampled when the access begins: byte-wide memory takes 5 clocks by default, and nibble-wide memory takes 8 because each byte needs two nibble transfers. A client that keeps its request asserted after done gets back-to-back accesses with no idle cycle, which is how bursts work. The arbiter chooses again at every access boundary. A higher-priority request can therefore break into a burst between two accesses, and the burst resumes once that access ends. Refresh is raised periodically and wins the next boundary for one access.

Top module: `dram_slot_arbiter`

## Requirements
- R1: At most one grant is high in any cycle, and all grants are low after reset.
- R2: When the arbiter is idle, a request present at a rising edge produces its grant right after that edge.
- R3: At each decision the fixed order, highest first, is refresh, frame data (`fe_req[0]`), flag data (`fe_req[1]`), microcontroller, subcode data (`fe_req[2]`), Q-channel data (`fe_req[3]`), status byte (`fe_req[4]`), SCSI, and ECC last.
- R4: An access lasts `BYTE_CYC` clocks (5) when `byte_mode` is 1 and `NIB_CYC` clocks (8) when it is 0. The width is taken at the first edge of the access, and later changes of `byte_mode` do not alter that access.
- R5: The granted client's done output is high only on the last cycle of its access. All other done outputs stay low.
- R6: A grant holds unchanged for the whole access. If requests are pending at done, the next grant follows on the very next cycle with no idle cycle. A client that keeps requesting therefore gets a continuous burst.
- R7: A higher-priority request raised during a burst is served at the next access boundary. The burst resumes right after that access if its request is still held.
- R8: A refresh request is raised every `REF_INT` clocks. It waits until the current access has finished, then takes exactly one access. Its grant is never issued while another access is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| byte_mode | input | 1 | 1: byte-wide memory, 0: nibble-wide memory |
| fe_req | input | 5 | Front-end requests: 0 frame, 1 flag, 2 subcode, 3 Q-channel, 4 status |
| mcu_req | input | 1 | Microcontroller request |
| scsi_req | input | 1 | SCSI interface request |
| ecc_req | input | 1 | ECC engine request |
| fe_gnt | output | 5 | Front-end grants, same bit order as `fe_req` |
| mcu_gnt | output | 1 | Microcontroller grant |
| scsi_gnt | output | 1 | SCSI grant |
| ecc_gnt | output | 1 | ECC grant |
| ref_gnt | output | 1 | Refresh grant |
| fe_done | output | 5 | Front-end last-cycle pulses |
| mcu_done | output | 1 | Microcontroller last-cycle pulse |
| scsi_done | output | 1 | SCSI last-cycle pulse |
| ecc_done | output | 1 | ECC last-cycle pulse |
| ref_done | output | 1 | Refresh last-cycle pulse |

## Verification
A corrupted cycle counter or latched length shows up as a done pulse in the wrong cycle within one access, and the next grant then starts early or late. A wrong priority choice or a stuck grant register is visible in the first cycle after the edge where the choice is made, as the wrong grant bit or as two grants at once. A refresh pending flag that is lost or never cleared shows within one refresh interval: refresh grants are missing, or they repeat back to back. The sweeps drive every request combination in both memory widths, so each of these faults meets a check within a few clocks.

// File: rtl/dram_slot_arbiter.sv
module dram_slot_arbiter #(
  parameter int BYTE_CYC = 5,
  parameter int NIB_CYC  = 8,
  parameter int REF_INT  = 529
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       byte_mode,
  input  logic [4:0] fe_req,
  input  logic       mcu_req,
  input  logic       scsi_req,
  input  logic       ecc_req,
  output logic [4:0] fe_gnt,
  output logic       mcu_gnt,
  output logic       scsi_gnt,
  output logic       ecc_gnt,
  output logic       ref_gnt,
  output logic [4:0] fe_done,
  output logic       mcu_done,
  output logic       scsi_done,
  output logic       ecc_done,
  output logic       ref_done
);
  localparam int MAXC = (NIB_CYC > BYTE_CYC) ? NIB_CYC : BYTE_CYC;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int RW   = (REF_INT > 1) ? $clog2(REF_INT) : 1;
  localparam int NC   = 9;

  // slot index = priority rank: 0 refresh, 1 frame, 2 flag, 3 mcu,
  // 4 subcode, 5 q, 6 status, 7 scsi, 8 ecc
  logic [NC-1:0] gnt, req_all, pick, done_v;
  logic [CW-1:0] cyc, len;
  logic [RW-1:0] rcnt;
  logic          rpend, busy, last, turn, tick;

  assign req_all = {ecc_req, scsi_req, fe_req[4], fe_req[3], fe_req[2],
                    mcu_req, fe_req[1], fe_req[0], rpend};
  assign pick    = req_all & (~req_all + NC'(1));
  assign busy    = |gnt;
  assign last    = busy && (cyc == len - CW'(1));
  assign turn    = !busy || last;
  assign tick    = (rcnt == RW'(REF_INT - 1));
  assign done_v  = gnt & {NC{last}};

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt   <= '0;
      cyc   <= '0;
      len   <= CW'(BYTE_CYC);
      rcnt  <= '0;
      rpend <= 1'b0;
    end else begin
      rcnt  <= tick ? '0 : rcnt + RW'(1);
      rpend <= (rpend & ~(turn & pick[0])) | tick;
      if (turn) begin
        gnt <= pick;
        cyc <= '0;
        len <= byte_mode ? CW'(BYTE_CYC) : CW'(NIB_CYC);
      end else begin
        cyc <= cyc + CW'(1);
      end
    end
  end

  assign ref_gnt   = gnt[0];
  assign fe_gnt    = {gnt[6], gnt[5], gnt[4], gnt[2], gnt[1]};
  assign mcu_gnt   = gnt[3];
  assign scsi_gnt  = gnt[7];
  assign ecc_gnt   = gnt[8];
  assign ref_done  = done_v[0];
  assign fe_done   = {done_v[6], done_v[5], done_v[4], done_v[2], done_v[1]};
  assign mcu_done  = done_v[3];
  assign scsi_done = done_v[7];
  assign ecc_done  = done_v[8];

  assert_one_grant_R1: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ref_gnt, fe_gnt, mcu_gnt, scsi_gnt, ecc_gnt}));

  assert_idle_start_R2: assert property (@(posedge clk) disable iff (rst)
    (!busy && (|req_all)) |=> busy);

  assert_len_bound_R4: assert property (@(posedge clk) disable iff (rst)
    busy |-> (cyc < len && (len == CW'(BYTE_CYC) || len == CW'(NIB_CYC))));

  assert_done_before_drop_R5: assert property (@(posedge clk) disable iff (rst)
    (|($past(gnt) & ~gnt)) |-> (|$past(done_v)));

  assert_hold_grant_R6: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> $stable(gnt));

  assert_refresh_next_R8: assert property (@(posedge clk) disable iff (rst)
    (rpend && turn) |=> ref_gnt);
endmodule

// File: tb/test_dram_slot_arbiter.sv
module test_dram_slot_arbiter;
  localparam int CLK_PER = 10;
  localparam int BC = 5;
  localparam int NCY = 8;
  localparam int RINT = 40;

  logic clk = 0, rst = 1;
  always #(CLK_PER/2) clk = ~clk;

  logic bm = 1;
  logic [4:0] fe = 0;
  logic mr = 0, sr = 0, er = 0;
  logic [4:0] feg, fed;
  logic mg, sg, eg, rg, md, sd, ed, rd;

  logic [4:0] feg2, fed2;
  logic mr2 = 1;
  logic mg2, sg2, eg2, rg2, md2, sd2, ed2, rd2;

  dram_slot_arbiter #(.BYTE_CYC(BC), .NIB_CYC(NCY), .REF_INT(1000000)) i_dram_slot_arbiter (
    .clk(clk), .rst(rst), .byte_mode(bm), .fe_req(fe), .mcu_req(mr),
    .scsi_req(sr), .ecc_req(er), .fe_gnt(feg), .mcu_gnt(mg), .scsi_gnt(sg),
    .ecc_gnt(eg), .ref_gnt(rg), .fe_done(fed), .mcu_done(md), .scsi_done(sd),
    .ecc_done(ed), .ref_done(rd));

  dram_slot_arbiter #(.BYTE_CYC(BC), .NIB_CYC(NCY), .REF_INT(RINT)) i_dram_slot_arbiter_ref (
    .clk(clk), .rst(rst), .byte_mode(1'b1), .fe_req(5'b0), .mcu_req(mr2),
    .scsi_req(1'b0), .ecc_req(1'b0), .fe_gnt(feg2), .mcu_gnt(mg2), .scsi_gnt(sg2),
    .ecc_gnt(eg2), .ref_gnt(rg2), .fe_done(fed2), .mcu_done(md2), .scsi_done(sd2),
    .ecc_done(ed2), .ref_done(rd2));

  // vector order: [0]frame [1]flag [2]sub [3]q [4]status [5]mcu [6]scsi [7]ecc [8]ref
  wire [8:0] gv = {rg, eg, sg, mg, feg};
  wire [8:0] dv = {rd, ed, sd, md, fed};

  int checks = 0, errors = 0, cycles = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [8:0] expect_gnt(input logic [7:0] p);
    int order [8] = '{0, 1, 5, 2, 3, 4, 6, 7};
    for (int i = 0; i < 8; i++)
      if (p[order[i]]) return 9'(1) << order[i];
    return '0;
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic drive(input logic [7:0] p);
    fe = p[4:0]; mr = p[5]; sr = p[6]; er = p[7];
  endtask

  initial begin
    logic [8:0] g0, eg0;
    int len;
    int rises [3];
    int nr;
    logic prev_rg, prev_md;
    int run;
    repeat (3) @(posedge clk);
    #1;
    chk(gv == 0 && rg2 == 0 && mg2 == 0, "R1 reset", gv, 0);
    rst = 0;

    // R2 R3 R4 R5 R6 sweep over all patterns and both widths
    for (int m = 0; m < 2; m++) begin
      bm = m[0];
      len = m ? BC : NCY;
      for (int p = 0; p < 256; p++) begin
        drive(p[7:0]);
        eg0 = expect_gnt(p[7:0]);
        @(posedge clk); #1;
        g0 = gv;
        chk(g0 == eg0, "R3 R2 priority grant", g0, eg0);
        chk($countones(g0) <= 1, "R1 one grant", g0, eg0);
        if (p != 0) begin
          for (int k = 0; k < len; k++) begin
            if (k > 0) begin @(posedge clk); #1; end
            chk(gv == g0, "R6 grant held", gv, g0);
            chk(dv == ((k == len - 1) ? g0 : 9'd0), "R4 R5 done timing", dv,
                (k == len - 1) ? g0 : 9'd0);
          end
          drive(8'h00);
          @(posedge clk); #1;
          chk(gv == 0, "R6 idle after drop", gv, 0);
        end
      end
    end

    // R4 width change mid-access ignored
    bm = 1; drive(8'h20);
    @(posedge clk); #1;
    bm = 0;
    for (int k = 0; k < BC; k++) begin
      if (k > 0) begin @(posedge clk); #1; end
      chk(md == (k == BC - 1), "R4 width latched", md, k == BC - 1);
    end
    drive(8'h00);
    @(posedge clk); #1;
    chk(gv == 0, "R4 idle after", gv, 0);
    bm = 1;

    // R6 R7 ECC burst broken by SCSI, then resumed
    drive(8'h80);
    @(posedge clk); #1;
    chk(eg == 1, "R6 ecc burst start", eg, 1);
    for (int k = 1; k < BC; k++) begin
      @(posedge clk); #1;
      if (k == 2) sr = 1;
      chk(eg == 1, "R6 ecc held", eg, 1);
    end
    chk(ed == 1, "R5 ecc done", ed, 1);
    @(posedge clk); #1;
    chk(sg == 1 && eg == 0, "R7 scsi breaks burst", gv, 9'h040);
    for (int k = 1; k < BC; k++) begin @(posedge clk); #1; end
    chk(sd == 1, "R5 scsi done", sd, 1);
    sr = 0;
    @(posedge clk); #1;
    chk(eg == 1 && sg == 0, "R7 ecc burst resumes", gv, 9'h080);
    for (int k = 1; k < BC; k++) begin @(posedge clk); #1; end
    chk(ed == 1, "R6 ecc second done", ed, 1);
    @(posedge clk); #1;
    chk(eg == 1 && ed == 0, "R6 back to back no gap", gv, 9'h080);
    for (int k = 1; k < BC; k++) begin @(posedge clk); #1; end
    er = 0;
    @(posedge clk); #1;
    chk(gv == 0, "R6 burst end", gv, 0);

    // R8 refresh on second instance, mcu requesting continuously
    nr = 0; prev_rg = rg2; prev_md = md2; run = 0;
    for (int c = 0; c < 200 && nr < 3; c++) begin
      @(posedge clk); #1;
      if (rg2 && !prev_rg) begin
        chk(prev_md == 1, "R8 refresh after access end", prev_md, 1);
        rises[nr] = c;
        nr++;
      end
      if (rg2) begin
        run++;
        chk(mg2 == 0, "R1 refresh exclusive", mg2, 0);
        if (rd2) chk(run == BC, "R8 one refresh access", run, BC);
      end else run = 0;
      prev_rg = rg2; prev_md = md2;
    end
    chk(nr == 3, "R8 refresh seen", nr, 3);
    if (nr == 3) chk(rises[2] - rises[1] == RINT, "R8 refresh interval",
                     rises[2] - rises[1], RINT);

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule